// File: doc/BRIEF.md
# Single-Register Early Load-Address Calculator

This block produces a load's effective address while the load is still in the first decode stage. It keeps one private copy of a general-purpose register, together with a tag that names the register it mirrors. A load marked "early-calculate" that uses register-plus-offset addressing binds this copy to its base register. Every early load adds its sign-extended offset to the cached value with a full-width carry-propagate adder. When a data-cache port is free, the block raises a speculative cache request at that address.

One cycle later, in the verify cycle, the block judges whether the speculatively loaded data may be forwarded. It needs a correct tag, no interlock on the cached register, no memory interlock, an allocated port and a cache hit. A wrong guess needs no recovery, because the normal load still runs. The decode input is a valid-only stream with no ready: the block accepts one decoded load per cycle and never applies back-pressure. The cache request is a plain strobe, and a cache that cannot take it simply drops it. Register-file writebacks are watched through one comparison against the tag.

Top module: `early_addr_calc`

## Requirements
- R1: After reset the cached register is unbound, holding value 0 and tag 0. No load can forward until a binding has completed in an earlier cycle, so the first early load after reset never forwards.
- R2: A valid load with `dec_kind` = 2'b10 (early) and `dec_regoff` = 1 binds the cached register at the clock edge. The tag becomes `dec_base` and the value becomes `rf_base_data`.
- R3: `early_addr` is combinational and always equals the cached value plus `dec_offset`, sign-extended to the address width. The sum wraps modulo 2^AW.
- R4: A writeback with `wb_en` = 1 updates the cached value at the next edge when `wb_reg` equals the tag of a bound register. When a binding and a writeback to the same register fall in the same cycle, the writeback data wins.
- R5: `spec_req` is high in the same cycle exactly when a valid early register-plus-offset load is decoded and `port_free` is 1.
- R6: `fwd_ok` rises one cycle after a `spec_req` whose base register matched the tag of a bound register. It also needs that verify cycle to have `cache_hit` = 1, `base_interlock` = 0 and `mem_interlock` = 0. It is low at all other times.
- R7: A load that switches the binding to a different register, or that finds the register unbound, never forwards, even though it still issues its speculative request.
- R8: Kinds 2'b00 (normal), 2'b01 (predict) and 2'b11 (reserved), as well as early loads with `dec_regoff` = 0, neither bind nor request. The cached value and tag stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | A decoded load is present this cycle |
| dec_kind | input | 2 | Load scheme: 00 normal, 01 predict, 10 early, 11 reserved |
| dec_regoff | input | 1 | 1 when the load uses register-plus-offset addressing |
| dec_base | input | RW | Base register number |
| dec_offset | input | OW | Signed address offset |
| rf_base_data | input | AW | Register-file value of the base register |
| wb_en | input | 1 | Register-file writeback strobe |
| wb_reg | input | RW | Writeback destination register |
| wb_data | input | AW | Writeback data |
| base_interlock | input | 1 | Pending write on the cached register (verify cycle) |
| mem_interlock | input | 1 | Memory-ordering conflict (verify cycle) |
| port_free | input | 1 | A data-cache port is available (decode cycle) |
| cache_hit | input | 1 | The speculative access hit (verify cycle) |
| early_addr | output | AW | Early effective address |
| spec_req | output | 1 | Speculative cache access request |
| fwd_ok | output | 1 | Speculative data may be forwarded |

## Verification
`early_addr` and `spec_req` are due in the same cycle as the decode inputs that produce them. `fwd_ok` is due exactly one cycle later, and it combines the candidate flag kept from decode with the hit and interlock flags of the verify cycle. The bench drives inputs on the falling edge and compares all three outputs against its own model one time unit later, before the next rising edge. After that edge it advances the model's binding state and carries its forwarding candidate into the next cycle.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    LK_NORMAL  = 2'b00,
    LK_PREDICT = 2'b01,
    LK_EARLY   = 2'b10,
    LK_RSVD    = 2'b11
  } load_kind_e;
endpackage

// File: rtl/ea_bind_reg.sv
module ea_bind_reg #(
  parameter int AW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bind_en,
  input  logic [RW-1:0] bind_reg,
  input  logic [AW-1:0] bind_data,
  input  logic          wb_en,
  input  logic [RW-1:0] wb_reg,
  input  logic [AW-1:0] wb_data,
  output logic          bound,
  output logic [RW-1:0] tag,
  output logic [AW-1:0] value
);
  logic          wb_to_new;
  logic          wb_to_tag;
  logic [AW-1:0] value_d;

  assign wb_to_new = wb_en && (wb_reg == bind_reg);
  assign wb_to_tag = wb_en && bound && (wb_reg == tag);

  always_comb begin
    value_d = value;
    if (bind_en)        value_d = wb_to_new ? wb_data : bind_data;
    else if (wb_to_tag) value_d = wb_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bound <= 1'b0;
      tag   <= '0;
      value <= '0;
    end else begin
      value <= value_d;
      if (bind_en) begin
        bound <= 1'b1;
        tag   <= bind_reg;
      end
    end
  end

  a_r2_bind_sets_tag: assert property (@(posedge clk) disable iff (!rst_n)
    bind_en |=> (bound && tag == $past(bind_reg)));

  a_r4_wb_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    (!bind_en && wb_en && bound && wb_reg == tag) |=> (value == $past(wb_data)));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!bind_en && !wb_en) |=> ($stable(value) && $stable(tag) && $stable(bound)));
endmodule

// File: rtl/ea_adder.sv
module ea_adder #(
  parameter int AW = 32,
  parameter int OW = 16,
  parameter bit SIGNED_OFFSET = 1'b1
) (
  input  logic [AW-1:0] base,
  input  logic [OW-1:0] offset,
  output logic [AW-1:0] sum
);
  localparam int EXT = AW - OW;
  logic [AW-1:0] off_ext;

  generate
    if (SIGNED_OFFSET) begin : g_sext
      assign off_ext = {{EXT{offset[OW-1]}}, offset};
    end else begin : g_zext
      assign off_ext = {{EXT{1'b0}}, offset};
    end
  endgenerate

  assign sum = base + off_ext;
endmodule

// File: rtl/ea_verify.sv
module ea_verify (
  input  logic clk,
  input  logic rst_n,
  input  logic candidate,
  input  logic cache_hit,
  input  logic base_interlock,
  input  logic mem_interlock,
  output logic fwd_ok
);
  logic cand_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cand_q <= 1'b0;
    else        cand_q <= candidate;
  end

  assign fwd_ok = cand_q && cache_hit && !base_interlock && !mem_interlock;

  a_r6_fwd_follows_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_ok |-> $past(candidate));
endmodule

// File: rtl/early_addr_calc.sv
module early_addr_calc #(
  parameter int AW = 32,
  parameter int RW = 5,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid,
  input  logic [1:0]    dec_kind,
  input  logic          dec_regoff,
  input  logic [RW-1:0] dec_base,
  input  logic [OW-1:0] dec_offset,
  input  logic [AW-1:0] rf_base_data,
  input  logic          wb_en,
  input  logic [RW-1:0] wb_reg,
  input  logic [AW-1:0] wb_data,
  input  logic          base_interlock,
  input  logic          mem_interlock,
  input  logic          port_free,
  input  logic          cache_hit,
  output logic [AW-1:0] early_addr,
  output logic          spec_req,
  output logic          fwd_ok
);
  import ea_pkg::*;

  logic          is_early;
  logic          tag_hit;
  logic          candidate;
  logic          bound;
  logic [RW-1:0] tag;
  logic [AW-1:0] cached;

  assign is_early  = dec_valid && (load_kind_e'(dec_kind) == LK_EARLY) && dec_regoff;
  assign spec_req  = is_early && port_free;
  assign tag_hit   = bound && (tag == dec_base);
  assign candidate = spec_req && tag_hit;

  ea_bind_reg #(.AW(AW), .RW(RW)) u_bind (
    .clk(clk), .rst_n(rst_n),
    .bind_en(is_early), .bind_reg(dec_base), .bind_data(rf_base_data),
    .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data),
    .bound(bound), .tag(tag), .value(cached)
  );

  ea_adder #(.AW(AW), .OW(OW), .SIGNED_OFFSET(1'b1)) u_add (
    .base(cached), .offset(dec_offset), .sum(early_addr)
  );

  ea_verify u_ver (
    .clk(clk), .rst_n(rst_n), .candidate(candidate),
    .cache_hit(cache_hit), .base_interlock(base_interlock),
    .mem_interlock(mem_interlock), .fwd_ok(fwd_ok)
  );

  a_r5_req_needs_port: assert property (@(posedge clk) disable iff (!rst_n)
    spec_req |-> (dec_valid && port_free && dec_regoff));

  a_r7_switch_blocks_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_req && !tag_hit) |=> !fwd_ok);

  a_r1_unbound_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bound) |-> !fwd_ok);
endmodule

// File: tb/early_addr_calc_tb.sv
module early_addr_calc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid = 0, dec_regoff = 0;
  logic [1:0]  dec_kind = 0;
  logic [4:0]  dec_base = 0, wb_reg = 0;
  logic [15:0] dec_offset = 0;
  logic [31:0] rf_base_data = 0, wb_data = 0;
  logic        wb_en = 0, base_interlock = 0, mem_interlock = 0, port_free = 0, cache_hit = 0;
  logic [31:0] early_addr;
  logic        spec_req, fwd_ok;

  int checks = 0, fails = 0;
  logic        m_bound = 0, m_cand = 0;
  logic [4:0]  m_tag = 0;
  logic [31:0] m_val = 0;

  always #2 clk = ~clk;

  early_addr_calc u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic cyc(input logic v, input logic [1:0] k, input logic ro, input logic [4:0] b,
                     input logic [15:0] off, input logic [31:0] rfd, input logic we,
                     input logic [4:0] wr, input logic [31:0] wd, input logic bi,
                     input logic mi, input logic pf, input logic ch, input string tagname);
    logic early, req, hit;
    @(negedge clk);
    dec_valid = v; dec_kind = k; dec_regoff = ro; dec_base = b; dec_offset = off;
    rf_base_data = rfd; wb_en = we; wb_reg = wr; wb_data = wd;
    base_interlock = bi; mem_interlock = mi; port_free = pf; cache_hit = ch;
    #1;
    early = v && k == 2'b10 && ro;
    req   = early && pf;
    hit   = m_bound && m_tag == b;
    chk({tagname, " R3 addr"}, early_addr, m_val + {{16{off[15]}}, off});
    chk({tagname, " R5 req"}, {31'd0, spec_req}, {31'd0, req});
    chk({tagname, " R6 fwd"}, {31'd0, fwd_ok}, {31'd0, m_cand && ch && !bi && !mi});
    @(posedge clk); #1;
    m_cand = req && hit;
    if (early) begin
      m_val = (we && wr == b) ? wd : rfd;
      m_tag = b; m_bound = 1'b1;
    end else if (we && m_bound && wr == m_tag) begin
      m_val = wd;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset fwd", {31'd0, fwd_ok}, 32'd0);
    chk("R1 reset addr", early_addr, 32'd0);
    rst_n = 1'b1;
    // R1: first early load after reset cannot forward
    cyc(1, 2'b10, 1, 5'd3, 16'h0010, 32'h1000, 0, 0, 0, 0, 0, 1, 0, "R1");
    cyc(0, 2'b00, 0, 5'd3, 16'h0000, 32'h0,    0, 0, 0, 0, 0, 0, 1, "R1");
    // R2: bound value now used, and matching load forwards next cycle (R6)
    cyc(1, 2'b10, 1, 5'd3, 16'hFFFC, 32'h1000, 0, 0, 0, 0, 0, 1, 1, "R2");
    cyc(0, 2'b00, 0, 5'd0, 16'h0000, 32'h0,    0, 0, 0, 0, 0, 0, 1, "R6");
    // R6: interlocks and miss block forwarding
    cyc(1, 2'b10, 1, 5'd3, 16'h0004, 32'h1000, 0, 0, 0, 0, 0, 1, 1, "R6");
    cyc(1, 2'b10, 1, 5'd3, 16'h0004, 32'h1000, 0, 0, 0, 1, 0, 1, 1, "R6");
    cyc(1, 2'b10, 1, 5'd3, 16'h0004, 32'h1000, 0, 0, 0, 0, 1, 1, 0, "R6");
    // R4: writeback to tag updates value; same-cycle bind + wb takes wb data
    cyc(0, 2'b00, 0, 5'd0, 16'h0000, 32'h0, 1, 5'd3, 32'h2000, 0, 0, 0, 0, "R4");
    cyc(0, 2'b00, 0, 5'd0, 16'h0008, 32'h0, 1, 5'd4, 32'h9999, 0, 0, 0, 0, "R4");
    cyc(1, 2'b10, 1, 5'd5, 16'h0000, 32'h5000, 1, 5'd5, 32'h5500, 0, 0, 1, 0, "R4");
    cyc(0, 2'b00, 0, 5'd0, 16'h0002, 32'h0, 0, 0, 0, 0, 0, 0, 0, "R4");
    // R7: switch binding to a different register, no forward despite hit
    cyc(1, 2'b10, 1, 5'd6, 16'h0000, 32'h6000, 0, 0, 0, 0, 0, 1, 0, "R7");
    cyc(0, 2'b00, 0, 5'd0, 16'h0000, 32'h0, 0, 0, 0, 0, 0, 0, 1, "R7");
    // R8: other kinds and reg+reg early loads leave binding alone
    cyc(1, 2'b00, 1, 5'd7, 16'h0000, 32'hAAAA, 0, 0, 0, 0, 0, 1, 0, "R8");
    cyc(1, 2'b01, 1, 5'd7, 16'h0000, 32'hBBBB, 0, 0, 0, 0, 0, 1, 0, "R8");
    cyc(1, 2'b11, 1, 5'd7, 16'h0000, 32'hCCCC, 0, 0, 0, 0, 0, 1, 0, "R8");
    cyc(1, 2'b10, 0, 5'd7, 16'h0000, 32'hDDDD, 0, 0, 0, 0, 0, 1, 0, "R8");
    cyc(1, 2'b10, 1, 5'd6, 16'h0001, 32'h6000, 0, 0, 0, 0, 0, 1, 1, "R8");
    cyc(0, 2'b00, 0, 5'd0, 16'h0000, 32'h0, 0, 0, 0, 0, 0, 0, 1, "R8");
    // R3: wrap-around of the sum
    cyc(1, 2'b10, 1, 5'd8, 16'h0000, 32'hFFFF_FFF0, 0, 0, 0, 0, 0, 0, 0, "R3");
    cyc(0, 2'b00, 0, 5'd0, 16'h0020, 32'h0, 0, 0, 0, 0, 0, 0, 0, "R3");
    // mixed random traffic, all requirements
    for (int i = 0; i < 4000; i++) begin
      cyc($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)), $urandom_range(0, 5) != 0,
          5'($urandom_range(1, 3)), 16'($urandom), $urandom, $urandom_range(0, 2) == 0,
          5'($urandom_range(1, 4)), $urandom, $urandom_range(0, 4) == 0,
          $urandom_range(0, 4) == 0, $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
          "RND");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule